// File: doc/BRIEF.md
# Framed Three-Bit Odd-Parity Detector

This block takes a serial bit stream, one bit per clock whenever a valid strobe is high. It cuts the stream into back-to-back frames of three accepted bits. The frames never overlap. When the third bit of a frame arrives and the frame holds an odd number of ones (001, 010, 100 or 111), the block raises a single-cycle hit flag in that same cycle.

Idle cycles, when the strobe is low, may fall anywhere, including in the middle of a frame. Reset realigns the frame boundary, so the next accepted bit opens a new frame.

Inside, a minimized five-state machine tracks the frame. One state marks the frame start. Two states record the first bit. Two states record the parity of the first two bits. Each state has a fixed 3-bit code, chosen so that related states sit at adjacent codes.

Top module: `fpd_detector`

## Requirements
- R1: While rst_ni is low, hit_o is low. After rst_ni rises, the first accepted bit is the first bit of a new frame, even if reset came in the middle of a frame.
- R2: When the third accepted bit of a frame completes one of 001, 010, 100 or 111, hit_o is high in the cycle that bit is accepted. Bits are written in arrival order, earliest bit leftmost.
- R3: When the third accepted bit completes 000, 011, 101 or 110, hit_o stays low.
- R4: Frames do not overlap. The accepted bit after the third bit of a frame is the first bit of the next frame.
- R5: In a cycle with valid_i low, hit_o is low and bit_i has no effect. The frame position is held, so idle cycles inside a frame do not change which triple is checked.
- R6: hit_o is high only in a cycle where valid_i is high and the bit being accepted is a frame's third bit, and never in two back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| valid_i | input | 1 | High when bit_i is to be accepted this cycle |
| hit_o | output | 1 | Mealy flag: current frame matches on its third bit |

## Verification
The assertions assume that bit_i and valid_i settle well before each rising edge. This matters because hit_o follows them combinationally, with no register in between. They also assume the state register only ever holds the five codes the machine can reach. The bench meets the first point by changing inputs only on falling edges and sampling hit_o a nanosecond later. The bench has no way to reach the unused codes, so the second point holds by the next-state logic alone.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int unsigned STATE_W = 3;
  typedef logic [STATE_W-1:0] fpd_state_t;

  // adjacent codes: first-bit pair differs in bit0, parity pair differs in bit0
  localparam fpd_state_t ST_START = 3'b000;
  localparam fpd_state_t ST_HEAD0 = 3'b100;
  localparam fpd_state_t ST_HEAD1 = 3'b101;
  localparam fpd_state_t ST_EVEN  = 3'b110;  // prefix 00 or 11
  localparam fpd_state_t ST_ODD   = 3'b111;  // prefix 01 or 10

  function automatic logic is_legal(fpd_state_t s);
    return (s == ST_START) || (s == ST_HEAD0) || (s == ST_HEAD1) ||
           (s == ST_EVEN)  || (s == ST_ODD);
  endfunction
endpackage

// File: rtl/fpd_next.sv
module fpd_next
  import fpd_pkg::*;
(
  input  fpd_state_t state_i,
  input  logic       bit_i,
  input  logic       valid_i,
  output fpd_state_t state_o
);
  always_comb begin
    state_o = state_i;
    if (valid_i) begin
      unique case (state_i)
        ST_START: state_o = bit_i ? ST_HEAD1 : ST_HEAD0;
        ST_HEAD0: state_o = bit_i ? ST_ODD   : ST_EVEN;
        ST_HEAD1: state_o = bit_i ? ST_EVEN  : ST_ODD;
        default:  state_o = ST_START;  // third bit, or unused code recovery
      endcase
    end
  end
endmodule

// File: rtl/fpd_out.sv
module fpd_out
  import fpd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  fpd_state_t state_i,
  input  logic       bit_i,
  input  logic       valid_i,
  output logic       hit_o
);
  logic last_bit;
  assign last_bit = (state_i == ST_EVEN) || (state_i == ST_ODD);

  always_comb begin
    hit_o = 1'b0;
    if (valid_i && last_bit)
      hit_o = (state_i == ST_EVEN) ? bit_i : ~bit_i;
  end

  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !hit_o);
  // R6
  hit_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid_i && state_i[2:1] == 2'b11));
  // R2
  odd_even_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_i == ST_EVEN && bit_i) |-> hit_o);
endmodule

// File: rtl/fpd_detector.sv
module fpd_detector
  import fpd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic valid_i,
  output logic hit_o
);
  fpd_state_t state_q, state_d;

  fpd_next u_next (
    .state_i (state_q),
    .bit_i   (bit_i),
    .valid_i (valid_i),
    .state_o (state_d)
  );

  fpd_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_q),
    .bit_i   (bit_i),
    .valid_i (valid_i),
    .hit_o   (hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_START;
    else         state_q <= state_d;
  end

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));
  // R4
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q[2:1] == 2'b11) |=> (state_q == ST_START));
  // R6
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
  // R4
  legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_legal(state_q));
endmodule

// File: tb/sim_fpd_detector.sv
module sim_fpd_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic vld = 1'b0;
  logic hit;
  int checks = 0;
  int errors = 0;
  int pos = 0;
  int ones = 0;
  bit prev_hit = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fpd_detector u0 (.clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .valid_i(vld), .hit_o(hit));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // accept one bit; model expects hit on third bit with odd ones
  task automatic send(input logic b, input string req);
    logic exp;
    @(negedge clk);
    vld = 1'b1; bit_in = b;
    #1;
    exp = (pos == 2) && (((ones + b) % 2) == 1);
    check(req, hit, exp);
    if (hit && prev_hit) check("R6", 1'b1, 1'b0);
    prev_hit = hit;
    ones = (pos == 2) ? 0 : ones + b;
    pos = (pos + 1) % 3;
  endtask

  task automatic idle(input logic b);
    @(negedge clk);
    vld = 1'b0; bit_in = b;
    #1;
    check("R5", hit, 1'b0);
    prev_hit = hit;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b1; bit_in = 1'b1;
    #1;
    check("R1", hit, 1'b0);
    @(negedge clk);
    #1;
    check("R1", hit, 1'b0);
    rst_n = 1'b1; vld = 1'b0;
    pos = 0; ones = 0; prev_hit = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // all triples, back to back
    for (int t = 0; t < 8; t++)
      for (int k = 2; k >= 0; k--)
        send(t[k], ((t[0] ^ t[1] ^ t[2]) == 1) ? "R2" : "R3");
    // exhaustive 9-bit streams: three non-overlapping frames
    for (int s = 0; s < 512; s++)
      for (int k = 8; k >= 0; k--) send(s[k], "R4");
    // idle gaps at every frame position with toggling ignored data
    for (int s = 0; s < 64; s++)
      for (int k = 5; k >= 0; k--) begin
        if ((s + k) % 3 == 0) idle(~s[k]);
        if ((s + k) % 4 == 0) idle(s[k]);
        send(s[k], "R5");
      end
    // reset mid-frame realigns
    for (int m = 1; m < 3; m++) begin
      for (int k = 0; k < m; k++) send(1'b1, "R1");
      do_reset();
      send(1'b0, "R1"); send(1'b0, "R1"); send(1'b1, "R1");
      send(1'b1, "R1"); send(1'b1, "R1"); send(1'b0, "R1");
    end
    // long idle then hit still one cycle only
    for (int k = 0; k < 5; k++) idle(1'b1);
    send(1'b1, "R6"); send(1'b1, "R6"); send(1'b1, "R6");
    idle(1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule